// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital sequencer that sits beside a successive-approximation analog-to-digital converter with 32 multiplexed inputs. Software programs a first channel, a last channel, a scan mode and a result width. Any of three start sources (a software start, a timer pulse or an external trigger pulse) then launches a scan. The sequencer hands each channel number to the converter with a one-cycle start pulse and waits for the converter's done pulse. It then stores the 10-bit result in a low and a high data register, packed according to the selected width.

There are three scan modes. Single mode walks the range once and drops the busy flag. Continuous mode loops over the range until software aborts it. Stop mode converts one channel, then parks until the next start source arrives. A software abort ends any scan at once and discards a conversion that is still in flight. The channel readback then keeps showing where the scan halted, and the next start always begins again at the first channel. An end-of-pass flag is raised after every completed pass and is cleared by software.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, the current channel, both data registers and the end-of-pass flag read 0, and no converter start pulse is issued until a start source arrives.
- R2: While idle, a one-cycle pulse on any of sw_start, tmr_trig or ext_trig sets busy in the next cycle, sets the current channel to the first channel, and causes exactly one converter start pulse for that channel.
- R3: In single mode (mode code 00), the channels from first to last are converted once, in ascending order. Busy clears on the clock edge that accepts the last channel's done pulse, and the current channel then shows the last channel.
- R4: In continuous mode (mode code 01), the channel after the last channel is the first channel. Conversion restarts with no further trigger and continues until aborted.
- R5: In stop mode (mode codes 10 and 11), each conversion is followed by a pause in which busy stays 1 and no start pulse is issued. The next start source advances to the following channel, and the channel after the last one is the first.
- R6: A pulse on sw_abort clears busy on the next edge in every state and discards the result of a conversion still in flight, leaving both data registers unchanged. The current channel keeps the channel that was being converted or paused on.
- R7: After an abort, the next start converts the first channel, not the channel where the scan was interrupted.
- R8: Start sources that arrive while a channel is being issued or converted are ignored: they neither add conversions nor change the current channel.
- R9: When the last channel is numerically below the first channel, each pass converts only the first channel.
- R10: With the width bit at 0 (10-bit), data_lo receives result bits 7:0 and data_hi receives result bits 9:8.
- R11: With the width bit at 1 (8-bit), data_lo receives result bits 9:2 and data_hi is 0.
- R12: eoc_irq is set on the edge that accepts the done pulse ending a pass. A pulse on irq_clr clears it, and setting takes priority over clearing in the same cycle.
- R13: A configuration write (mode, width, first, last) made while busy is 1 is ignored. The running scan continues with the settings it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start pulse (write of 1 to busy) |
| sw_abort | input | 1 | Software abort pulse (write of 0 to busy) |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External trigger start pulse |
| cfg_we | input | 1 | Configuration write enable |
| cfg_mode | input | 2 | Scan mode: 00 single, 01 continuous, 1x stop |
| cfg_res8 | input | 1 | Result width: 0 is 10-bit, 1 is 8-bit |
| cfg_first | input | 5 | First channel of the scan range |
| cfg_last | input | 5 | Last channel of the scan range |
| irq_clr | input | 1 | Clears the end-of-pass flag |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | 5 | Channel selected for the converter |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_result | input | 10 | Converter result, valid with conv_done |
| busy | output | 1 | Scan active |
| cur_ch | output | 5 | Channel being converted, or channel where the scan halted |
| data_lo | output | 8 | Low data register |
| data_hi | output | 2 | High data register |
| eoc_irq | output | 1 | End-of-pass flag |

## Verification
The properties assume a well-behaved converter. It answers each start pulse with exactly one done pulse, and never raises done while no start is outstanding, except the single late done that belongs to an aborted conversion. They also assume that sw_start and sw_abort are never pulsed in the same cycle. The bench keeps to these assumptions with a converter model that handles one request at a time and always answers four cycles after the start. After every abort the stimulus waits long enough for the stale done to drain before it issues another start, and abort and start pulses are driven from separate, non-overlapping tasks.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PAUSE = 2'd3
  } seq_st_e;

  localparam logic [1:0] MD_SINGLE = 2'b00;
  localparam logic [1:0] MD_CONT   = 2'b01;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            sw_abort,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_res8,
  input  logic [CH_W-1:0] cfg_first,
  input  logic [CH_W-1:0] cfg_last,
  input  logic            conv_done,
  output logic            conv_start,
  output logic            busy,
  output logic [CH_W-1:0] cur_ch,
  output logic            res8,
  output logic [CH_W-1:0] first_q,
  output logic [CH_W-1:0] last_q,
  output logic            done_accept,
  output logic            pass_done,
  output logic            in_pause
);

  seq_st_e         st_q;
  logic [1:0]      mode_q;
  logic            pend;
  logic [CH_W-1:0] nxt_ch;

  // A pass ends on the last channel, or at once when the range is reversed.
  function automatic logic pass_end(input logic [CH_W-1:0] c,
                                    input logic [CH_W-1:0] f,
                                    input logic [CH_W-1:0] l);
    return (l < f) || (c == l);
  endfunction

  function automatic logic [CH_W-1:0] step_ch(input logic [CH_W-1:0] c,
                                              input logic [CH_W-1:0] f,
                                              input logic [CH_W-1:0] l);
    return pass_end(c, f, l) ? f : CH_W'(c + 1'b1);
  endfunction

  assign pend        = pass_end(cur_ch, first_q, last_q);
  assign nxt_ch      = step_ch(cur_ch, first_q, last_q);
  assign conv_start  = (st_q == ST_ISSUE);
  assign in_pause    = (st_q == ST_PAUSE);
  assign done_accept = (st_q == ST_WAIT) && conv_done && !sw_abort;
  assign pass_done   = done_accept && pend;

  // Configuration is frozen while a scan runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_SINGLE;
      res8    <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (cfg_we && !busy) begin
      mode_q  <= cfg_mode;
      res8    <= cfg_res8;
      first_q <= cfg_first;
      last_q  <= cfg_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      busy   <= 1'b0;
      cur_ch <= '0;
    end else if (sw_abort) begin
      st_q <= ST_IDLE;
      busy <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (trig) begin
            st_q   <= ST_ISSUE;
            busy   <= 1'b1;
            cur_ch <= first_q;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (conv_done) begin
            if (mode_q == MD_SINGLE) begin
              if (pend) begin
                st_q <= ST_IDLE;
                busy <= 1'b0;
              end else begin
                st_q   <= ST_ISSUE;
                cur_ch <= nxt_ch;
              end
            end else if (mode_q == MD_CONT) begin
              st_q   <= ST_ISSUE;
              cur_ch <= nxt_ch;
            end else begin
              st_q <= ST_PAUSE;
            end
          end
        end
        ST_PAUSE: begin
          if (trig) begin
            st_q   <= ST_ISSUE;
            cur_ch <= nxt_ch;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  localparam int HI_W = RES_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             res8,
  input  logic [RES_W-1:0] result,
  output logic [LO_W-1:0]  data_lo,
  output logic [HI_W-1:0]  data_hi
);

  // Narrow mode keeps the most significant LO_W bits in the low register.
  function automatic logic [LO_W-1:0] pack_lo(input logic [RES_W-1:0] r,
                                              input logic n);
    return n ? r[RES_W-1 -: LO_W] : r[LO_W-1:0];
  endfunction

  function automatic logic [HI_W-1:0] pack_hi(input logic [RES_W-1:0] r,
                                              input logic n);
    return n ? '0 : r[RES_W-1:LO_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_lo <= '0;
      data_hi <= '0;
    end else if (load) begin
      data_lo <= pack_lo(result, res8);
      data_hi <= pack_hi(result, res8);
    end
  end

endmodule

// File: rtl/adc_eoc_flag.sv
module adc_eoc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W  = 5,
  parameter int RES_W = 10,
  parameter int LO_W  = 8,
  localparam int HI_W = RES_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             sw_abort,
  input  logic             tmr_trig,
  input  logic             ext_trig,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_res8,
  input  logic [CH_W-1:0]  cfg_first,
  input  logic [CH_W-1:0]  cfg_last,
  input  logic             irq_clr,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             busy,
  output logic [CH_W-1:0]  cur_ch,
  output logic [LO_W-1:0]  data_lo,
  output logic [HI_W-1:0]  data_hi,
  output logic             eoc_irq
);

  logic            any_trig;
  logic            res8;
  logic [CH_W-1:0] first_q;
  logic [CH_W-1:0] last_q;
  logic            done_accept;
  logic            pass_done;
  logic            in_pause;

  assign any_trig = sw_start | tmr_trig | ext_trig;
  assign conv_ch  = cur_ch;

  adc_scan_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (any_trig),
    .sw_abort    (sw_abort),
    .cfg_we      (cfg_we),
    .cfg_mode    (cfg_mode),
    .cfg_res8    (cfg_res8),
    .cfg_first   (cfg_first),
    .cfg_last    (cfg_last),
    .conv_done   (conv_done),
    .conv_start  (conv_start),
    .busy        (busy),
    .cur_ch      (cur_ch),
    .res8        (res8),
    .first_q     (first_q),
    .last_q      (last_q),
    .done_accept (done_accept),
    .pass_done   (pass_done),
    .in_pause    (in_pause)
  );

  adc_result_pack #(.RES_W(RES_W), .LO_W(LO_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (done_accept),
    .res8    (res8),
    .result  (conv_result),
    .data_lo (data_lo),
    .data_hi (data_hi)
  );

  adc_eoc_flag u_eoc (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (pass_done),
    .clr   (irq_clr),
    .flag  (eoc_irq)
  );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int CH_W = 5,
  parameter int HI_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_abort,
  input logic            irq_clr,
  input logic            conv_start,
  input logic            conv_done,
  input logic            busy,
  input logic [CH_W-1:0] cur_ch,
  input logic [CH_W-1:0] first_q,
  input logic [CH_W-1:0] last_q,
  input logic            res8,
  input logic            done_accept,
  input logic            pass_done,
  input logic            in_pause,
  input logic [HI_W-1:0] data_hi,
  input logic            eoc_irq
);

  a_r1_start_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r3_channel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && (last_q >= first_q)) |-> ((cur_ch >= first_q) && (cur_ch <= last_q)));

  a_r5_pause_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (busy && !conv_start));

  a_r6_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sw_abort |=> !busy);

  a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_pause && !conv_done && !sw_abort) |=> $stable(cur_ch));

  a_r9_reverse_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && (last_q < first_q)) |-> (cur_ch == first_q));

  a_r11_hi_zero_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && res8) |=> (data_hi == '0));

  a_r12_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> eoc_irq);

  a_r12_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !pass_done) |=> !eoc_irq);

endmodule

bind adc_scan_seq adc_scan_chk #(.CH_W(CH_W), .HI_W(HI_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_abort    (sw_abort),
  .irq_clr     (irq_clr),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .busy        (busy),
  .cur_ch      (cur_ch),
  .first_q     (first_q),
  .last_q      (last_q),
  .res8        (res8),
  .done_accept (done_accept),
  .pass_done   (pass_done),
  .in_pause    (in_pause),
  .data_hi     (data_hi),
  .eoc_irq     (eoc_irq)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_start, sw_abort, tmr_trig, ext_trig;
  logic       cfg_we, cfg_res8, irq_clr;
  logic [1:0] cfg_mode;
  logic [4:0] cfg_first, cfg_last;
  logic       conv_start, conv_done;
  logic [4:0] conv_ch, cur_ch;
  logic [9:0] conv_result;
  logic       busy, eoc_irq;
  logic [7:0] data_lo;
  logic [1:0] data_hi;

  typedef struct {
    logic [4:0] ch;
    bit         upd;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, n_starts = 0, n_conv = 0;
  bit   res8_b = 1'b0, ended = 1'b0;
  logic [7:0] prev_lo = '0;
  logic [1:0] prev_hi = '0;

  always #10 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_abort(sw_abort),
    .tmr_trig(tmr_trig), .ext_trig(ext_trig), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_res8(cfg_res8), .cfg_first(cfg_first),
    .cfg_last(cfg_last), .irq_clr(irq_clr), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_result(conv_result),
    .busy(busy), .cur_ch(cur_ch), .data_lo(data_lo), .data_hi(data_hi),
    .eoc_irq(eoc_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic push(input int ch, input bit upd);
    exp_t it;
    it.ch  = 5'(ch);
    it.upd = upd;
    exp_q.push_back(it);
  endtask

  task automatic cfg(input int md, input bit n8, input int f, input int l, input bit taken);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 2'(md); cfg_res8 = n8;
    cfg_first = 5'(f); cfg_last = 5'(l);
    @(negedge clk);
    cfg_we = 1'b0;
    if (taken) res8_b = n8;
  endtask

  task automatic fire(input int src);
    @(negedge clk);
    case (src)
      0: sw_start = 1'b1;
      1: tmr_trig = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    @(negedge clk);
    sw_start = 1'b0; tmr_trig = 1'b0; ext_trig = 1'b0;
  endtask

  task automatic abort_pulse();
    @(negedge clk);
    sw_abort = 1'b1;
    @(negedge clk);
    sw_abort = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic settle(input int n);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_starts(input int target);
    while (n_starts < target) @(negedge clk);
  endtask

  // Converter model and scoreboard monitor.
  initial begin
    conv_done   = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      while (rst_n && conv_start) begin
        exp_t it;
        bit upd;
        logic [9:0] val;
        logic [7:0] e_lo;
        logic [1:0] e_hi;
        upd = 1'b0;
        n_starts++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 R5 R8 unexpected converter start on channel", int'(conv_ch), -1);
        end else begin
          it  = exp_q.pop_front();
          upd = it.upd;
          chk(conv_ch == it.ch, "R2 R3 R4 R5 R7 R9 channel order", int'(conv_ch), int'(it.ch));
        end
        val = 10'((int'(conv_ch) * 29 + n_conv * 13 + 7) % 1024);
        n_conv++;
        repeat (3) @(negedge clk);
        conv_result = val;
        conv_done   = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        if (upd) begin
          e_lo = res8_b ? val[9:2] : val[7:0];
          e_hi = res8_b ? 2'b00 : val[9:8];
        end else begin
          e_lo = prev_lo;
          e_hi = prev_hi;
        end
        chk(data_lo == e_lo, "R10 R11 R6 data_lo", int'(data_lo), int'(e_lo));
        chk(data_hi == e_hi, "R10 R11 R6 data_hi", int'(data_hi), int'(e_hi));
        prev_lo = e_lo;
        prev_hi = e_hi;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_starts, 0);
    finish_run();
  end

  initial begin
    int s;
    rst_n = 1'b0;
    sw_start = 0; sw_abort = 0; tmr_trig = 0; ext_trig = 0;
    cfg_we = 0; cfg_mode = 0; cfg_res8 = 0; cfg_first = 0; cfg_last = 0; irq_clr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state, no start without a trigger
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(cur_ch == 5'd0, "R1 cur_ch", int'(cur_ch), 0);
    chk(data_lo == 8'd0, "R1 data_lo", int'(data_lo), 0);
    chk(data_hi == 2'd0, "R1 data_hi", int'(data_hi), 0);
    chk(eoc_irq == 1'b0, "R1 eoc_irq", int'(eoc_irq), 0);
    chk(n_starts == 0, "R1 start count", n_starts, 0);

    // R3 R10 single pass, 10-bit, software start
    cfg(0, 1'b0, 3, 6, 1'b1);
    push(3, 1'b1); push(4, 1'b1); push(5, 1'b1); push(6, 1'b1);
    fire(0);
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(cur_ch == 5'd3, "R2 cur_ch is first", int'(cur_ch), 3);
    while (busy) @(negedge clk);
    settle(6);
    chk(busy == 1'b0, "R3 busy clears", int'(busy), 0);
    chk(cur_ch == 5'd6, "R3 cur_ch shows last", int'(cur_ch), 6);
    chk(eoc_irq == 1'b1, "R12 flag after pass", int'(eoc_irq), 1);
    clr_pulse();
    chk(eoc_irq == 1'b0, "R12 flag cleared", int'(eoc_irq), 0);

    // R11 8-bit, timer start
    cfg(0, 1'b1, 30, 31, 1'b1);
    push(30, 1'b1); push(31, 1'b1);
    fire(1);
    while (busy) @(negedge clk);
    settle(6);
    chk(cur_ch == 5'd31, "R11 cur_ch", int'(cur_ch), 31);
    chk(data_hi == 2'd0, "R11 data_hi zero", int'(data_hi), 0);

    // R9 reversed range, external trigger
    cfg(0, 1'b0, 9, 2, 1'b1);
    push(9, 1'b1);
    fire(2);
    while (busy) @(negedge clk);
    settle(6);
    chk(cur_ch == 5'd9, "R9 only first channel", int'(cur_ch), 9);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    // R8 retriggers while converting are ignored
    cfg(0, 1'b0, 0, 3, 1'b1);
    push(0, 1'b1); push(1, 1'b1); push(2, 1'b1); push(3, 1'b1);
    s = n_starts;
    fire(0);
    wait_starts(s + 2);
    fire(1);
    fire(2);
    fire(0);
    while (busy) @(negedge clk);
    settle(10);
    chk(n_starts - s == 4, "R8 conversion count", n_starts - s, 4);

    // R4 continuous wrap, then R6 abort mid-conversion
    clr_pulse();
    cfg(1, 1'b0, 5, 6, 1'b1);
    push(5, 1'b1); push(6, 1'b1); push(5, 1'b1); push(6, 1'b1); push(5, 1'b0);
    s = n_starts;
    fire(0);
    wait_starts(s + 5);
    abort_pulse();
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R6 busy after abort", int'(busy), 0);
    chk(cur_ch == 5'd5, "R6 halted channel", int'(cur_ch), 5);
    chk(eoc_irq == 1'b1, "R4 flag after wrap", int'(eoc_irq), 1);
    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

    // R7 restart after abort begins at first channel
    cfg(1, 1'b0, 4, 7, 1'b1);
    push(4, 1'b1); push(5, 1'b0);
    s = n_starts;
    fire(1);
    wait_starts(s + 2);
    abort_pulse();
    repeat (10) @(negedge clk);
    chk(cur_ch == 5'd5, "R6 halted channel second", int'(cur_ch), 5);
    push(4, 1'b0);
    s = n_starts;
    fire(2);
    wait_starts(s + 1);
    abort_pulse();
    repeat (10) @(negedge clk);
    chk(cur_ch == 5'd4, "R7 restart at first", int'(cur_ch), 4);
    chk(busy == 1'b0, "R7 busy after abort", int'(busy), 0);

    // R5 stop mode, R13 config ignored while busy
    clr_pulse();
    cfg(2, 1'b1, 1, 2, 1'b1);
    push(1, 1'b1);
    fire(1);
    settle(20);
    chk(busy == 1'b1, "R5 busy in pause", int'(busy), 1);
    chk(cur_ch == 5'd1, "R5 paused channel", int'(cur_ch), 1);
    chk(eoc_irq == 1'b0, "R5 no flag mid pass", int'(eoc_irq), 0);
    cfg(0, 1'b0, 20, 25, 1'b0);
    push(2, 1'b1);
    fire(2);
    settle(20);
    chk(cur_ch == 5'd2, "R13 config write ignored", int'(cur_ch), 2);
    chk(busy == 1'b1, "R13 still stop mode", int'(busy), 1);
    chk(eoc_irq == 1'b1, "R12 flag in stop mode", int'(eoc_irq), 1);
    push(1, 1'b1);
    fire(0);
    settle(20);
    chk(cur_ch == 5'd1, "R5 wrap to first", int'(cur_ch), 1);
    abort_pulse();
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R6 abort in pause", int'(busy), 0);
    chk(cur_ch == 5'd1, "R6 channel kept in pause", int'(cur_ch), 1);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule